// File: doc/BRIEF.md
# Preloaded Up-Counting Interval Timer

This block is a periodic interrupt source built around a 16-bit up-counter. A divider derived from the system clock frequency produces a one-cycle tick enable at 160 kHz. While the timer runs, each tick adds one to the counter. When the counter steps past its all-ones value, it picks up the preload value on that same tick and latches an interrupt. The interval is therefore (65536 - preload) ticks. For a target rate f, software programs a preload of 65536 - 160000/f.

Four registers sit behind a small address/strobe port: the preload value, the live count (read-only), a control byte and an interrupt-control byte. The interrupt-control byte holds a 3-bit priority level, an enable bit and a pending flag. The block drives an interrupt request together with its 3-bit level. Level 0 never produces a request.

The run control is a two-state machine. `ST_IDLE` is the stopped state, with the counter held at zero. `ST_RUN` is the counting state. A start command (control byte 0x03) moves `ST_IDLE` to `ST_RUN` and loads the preload into the counter. A clear command (control byte 0x00) moves `ST_RUN` back to `ST_IDLE` and zeroes the counter; in `ST_IDLE` the same command only zeroes the counter again. Every other control value, and a start command given in `ST_RUN`, leaves the state unchanged.

Top module: `preload_interval_timer`

## Requirements
- R1: After reset, all four registers read 0, the machine is in `ST_IDLE`, and irq_req is 0 with irq_level 0.
- R2: Address 0 is the preload register and holds all 16 bits of a write. Address 1 returns the live counter, and writes to address 1 have no effect. The byte registers (addresses 2 and 3) take only write-data bits [7:0] and read back zero-extended.
- R3: The tick enable is high for one cycle in every SYS_CLK_HZ/TICK_HZ system cycles. In `ST_RUN` the counter increases by exactly one per tick.
- R4: Writing 0x00 to address 2 enters `ST_IDLE` and sets the counter to 0. In `ST_IDLE` the counter holds its value across ticks.
- R5: Writing 0x03 to address 2 in `ST_IDLE` enters `ST_RUN` and loads the preload into the counter. In `ST_RUN` a start command has no effect, and any control value other than 0x00 or 0x03 has no effect in either state. Address 2 reads 0x03 in `ST_RUN` and 0x00 in `ST_IDLE`.
- R6: A tick in `ST_RUN` that finds the counter at 0xFFFF reloads the preload on that tick and sets the pending flag. Successive overflows are therefore (65536 - preload) ticks apart.
- R7: The interrupt-control byte (address 3) has the level in bits [2:0], the enable in bit 3 and pending in bit 7; the other bits read 0. A write updates the level and the enable. A 1 in written bit 7 (for example the acknowledge value 0x80) clears pending, and a 0 in bit 7 leaves pending unchanged.
- R8: When an overflow and an acknowledge write land on the same clock edge, pending ends set.
- R9: irq_req is 1 exactly when enable and pending are both 1 and the level is not 0. irq_level equals the programmed level while irq_req is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 preload, 1 count, 2 control, 3 interrupt control |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level of the request; 0 when no request is made |

## Verification
The hardest case to reach is R8, where an acknowledge write and an overflow land on the same edge, because the tick phase cannot be seen at the ports. The stimulus uses a preload of 0xFFFF so that every tick overflows. It first waits for irq_req to rise, which marks one tick edge. Because the tick period is known, it then times the acknowledge write to land exactly on the next tick edge, and a second write lands one cycle earlier as a control case. The bench measures interval lengths between interrupt edges for randomly chosen preloads. A seeded random register phase exercises preload storage, the read-only count, ignored control values and the pending semantics.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam logic [1:0] ADDR_PRELOAD = 2'd0;
    localparam logic [1:0] ADDR_COUNT   = 2'd1;
    localparam logic [1:0] ADDR_CTRL    = 2'd2;
    localparam logic [1:0] ADDR_IRQ     = 2'd3;

    localparam logic [7:0] CMD_CLEAR = 8'h00;
    localparam logic [7:0] CMD_START = 8'h03;

    typedef struct packed {
        logic       pending;
        logic       enable;
        logic [2:0] level;
    } irq_cfg_t;

endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
    parameter int unsigned DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        tick = (div_q == LAST);
    end

    generate
        if (DIV > 1) begin : g_gap_chk
            // R3: a tick is always followed by at least one idle cycle
            assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ivt_count_fsm.sv
module ivt_count_fsm
    import ivt_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ctrl_wr,
    input  logic [7:0]   ctrl_val,
    input  logic [W-1:0] preload,
    output logic [W-1:0] count,
    output logic         running,
    output logic         overflow
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    run_state_e   state_q, state_d;
    logic [W-1:0] count_q;
    logic         clr_cmd, start_cmd;

    always_comb begin
        clr_cmd   = ctrl_wr && (ctrl_val == CMD_CLEAR);
        start_cmd = ctrl_wr && (ctrl_val == CMD_START);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_cmd) state_d = ST_RUN;
            ST_RUN:  if (clr_cmd)   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_cmd) begin
            count_q <= '0;
        end else if (state_q == ST_IDLE && start_cmd) begin
            count_q <= preload;
        end else if (state_q == ST_RUN && tick) begin
            if (count_q == CNT_MAX) begin
                count_q <= preload;
            end else begin
                count_q <= count_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        count    = count_q;
        running  = (state_q == ST_RUN);
        overflow = (state_q == ST_RUN) && tick && (count_q == CNT_MAX) && !clr_cmd;
    end

    // R3: one step per tick while running
    assert_run_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && count_q != CNT_MAX && !clr_cmd)
        |=> count_q == W'($past(count_q) + 1'b1));

    // R4: stopped counter holds
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_cmd && !clr_cmd) |=> $stable(count_q));

    // R4: clear command zeroes the counter and stops
    assert_clear_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (count_q == '0 && state_q == ST_IDLE));

    // R6: wrap reloads the preload
    assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tick && count_q == CNT_MAX && !clr_cmd)
        |=> count_q == $past(preload));

endmodule

// File: rtl/ivt_irq_ctl.sv
module ivt_irq_ctl
    import ivt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_data,
    input  logic       overflow,
    output irq_cfg_t   cfg,
    output logic       irq_req,
    output logic [2:0] irq_level
);

    irq_cfg_t cfg_q;
    logic     unused_bits;

    always_comb begin
        unused_bits = ^cfg_data[6:4];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (cfg_wr) begin
                cfg_q.level  <= cfg_data[2:0];
                cfg_q.enable <= cfg_data[3];
                if (cfg_data[7]) begin
                    cfg_q.pending <= 1'b0;
                end
            end
            // a new event wins over a coincident acknowledge
            if (overflow) begin
                cfg_q.pending <= 1'b1;
            end
        end
    end

    always_comb begin
        cfg       = cfg_q;
        irq_req   = cfg_q.enable && cfg_q.pending && (cfg_q.level != 3'd0);
        irq_level = irq_req ? cfg_q.level : 3'd0;
    end

    // R8: overflow always leaves pending set
    assert_ovf_sets_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> cfg_q.pending);

    // R6: pending only rises because of an overflow
    assert_pending_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q.pending) |-> $past(overflow));

    // R7: acknowledge without a new event clears pending
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data[7] && !overflow) |=> !cfg_q.pending);

endmodule

// File: rtl/preload_interval_timer.sv
module preload_interval_timer
    import ivt_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 1_600_000,
    parameter int unsigned TICK_HZ    = 160_000,
    parameter int unsigned CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_req,
    output logic [2:0]       irq_level
);

    localparam int unsigned DIV = (SYS_CLK_HZ / TICK_HZ > 0) ? SYS_CLK_HZ / TICK_HZ : 1;

    logic [CNT_W-1:0] preload_q;
    logic [CNT_W-1:0] count;
    logic             tick, running, overflow;
    logic             ctrl_wr, irq_wr, pre_wr;
    irq_cfg_t         cfg;

    always_comb begin
        pre_wr  = bus_wr && (bus_addr == ADDR_PRELOAD);
        ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
        irq_wr  = bus_wr && (bus_addr == ADDR_IRQ);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= '0;
        end else if (pre_wr) begin
            preload_q <= bus_wdata;
        end
    end

    ivt_tick_gen #(.DIV(DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ivt_count_fsm #(.W(CNT_W)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctrl_wr  (ctrl_wr),
        .ctrl_val (bus_wdata[7:0]),
        .preload  (preload_q),
        .count    (count),
        .running  (running),
        .overflow (overflow)
    );

    ivt_irq_ctl irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (irq_wr),
        .cfg_data  (bus_wdata[7:0]),
        .overflow  (overflow),
        .cfg       (cfg),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_PRELOAD: bus_rdata = preload_q;
            ADDR_COUNT:   bus_rdata = count;
            ADDR_CTRL:    bus_rdata = CNT_W'(running ? CMD_START : CMD_CLEAR);
            ADDR_IRQ:     bus_rdata = CNT_W'({cfg.pending, 3'b000, cfg.enable, cfg.level});
            default:      bus_rdata = '0;
        endcase
    end

    // R2: preload changes only through its own address
    assert_preload_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_wr |=> $stable(preload_q));

    // R9: a request always carries a non-zero level
    assert_req_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != 3'd0));

    // R9: no request means level 0
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_level == 3'd0));

endmodule

// File: tb/preload_interval_timer_tb_top.sv
module preload_interval_timer_tb_top;

    localparam int SYS_HZ = 1_600_000;
    localparam int TK_HZ  = 160_000;
    localparam int DIV    = SYS_HZ / TK_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq_req;
    logic [2:0]  irq_level;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    preload_interval_timer #(.SYS_CLK_HZ(SYS_HZ), .TICK_HZ(TK_HZ), .CNT_W(16)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [15:0] irq_byte(bit p, bit e, logic [2:0] l);
        return {8'h00, p, 3'b000, e, l};
    endfunction

    function automatic int period_cycles(logic [15:0] p);
        return (65536 - int'(p)) * DIV;
    endfunction

    function automatic bit exp_req(bit p, bit e, logic [2:0] l);
        return p && e && (l != 3'd0);
    endfunction

    task automatic wait_rise(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (irq_req) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c, p;
        bit ok, m_pend, m_en;
        logic [2:0] m_lvl;
        int t1, t2;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 preload", v, 16'h0);
        rd(2'd1, v); check("R1 count", v, 16'h0);
        rd(2'd2, v); check("R1 ctrl", v, 16'h0);
        rd(2'd3, v); check("R1 irqbyte", v, 16'h0);
        check("R1 irq_req", {15'd0, irq_req}, 16'h0);

        // random register phase, timer idle: R2 R5 R7 R9
        m_pend = 0; m_en = 0; m_lvl = 0;
        for (int i = 0; i < 30; i++) begin
            int sel;
            logic [15:0] d;
            sel = $urandom % 4;
            d = 16'($urandom);
            case (sel)
                0: begin
                    wr(2'd0, d); rd(2'd0, v); check("R2 preload rw", v, d);
                end
                1: begin
                    wr(2'd1, d); rd(2'd1, v); check("R2 count write ignored", v, 16'h0);
                end
                2: begin
                    wr(2'd3, d);
                    m_lvl = d[2:0]; m_en = d[3];
                    if (d[7]) m_pend = 0;
                    rd(2'd3, v); check("R7 irq byte", v, irq_byte(m_pend, m_en, m_lvl));
                    check("R9 req idle", {15'd0, irq_req}, {15'd0, exp_req(m_pend, m_en, m_lvl)});
                end
                default: begin
                    if (d[7:0] == 8'h00 || d[7:0] == 8'h03) d[7:0] = 8'h41;
                    wr(2'd2, d);
                    rd(2'd2, v); check("R5 other ctrl ignored", v, 16'h0);
                    rd(2'd1, v); check("R5 count untouched", v, 16'h0);
                end
            endcase
        end

        // R5 start loads preload
        wr(2'd3, 16'h0080);
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'h0003);
        rd(2'd1, v); check("R5 start loads preload", v, 16'h1234);
        rd(2'd2, v); check("R5 ctrl reads run", v, 16'h0003);

        // R3 exactly one step per DIV cycles
        rd(2'd1, c);
        repeat (DIV - 1) @(negedge clk);
        rd(2'd1, v); check("R3 one step", v, c + 16'd1);
        repeat (5 * DIV - 1) @(negedge clk);
        rd(2'd1, v); check("R3 five steps", v, c + 16'd6);

        // R5 start while running ignored, other value ignored
        wr(2'd0, 16'h0100);
        rd(2'd1, c);
        wr(2'd2, 16'h0003);
        rd(2'd1, v);
        n_chk++;
        if (v !== c && v !== c + 16'd1) begin
            n_err++;
            $display("FAIL R5 restart ignored: actual=%h expected=%h or %h", v, c, c + 16'd1);
        end
        wr(2'd2, 16'h0001);
        rd(2'd2, v); check("R5 0x01 ignored in run", v, 16'h0003);

        // R4 clear and hold
        wr(2'd2, 16'h0000);
        rd(2'd1, v); check("R4 clear zero", v, 16'h0);
        rd(2'd2, v); check("R4 ctrl idle", v, 16'h0);
        repeat (3 * DIV) @(negedge clk);
        rd(2'd1, v); check("R4 hold", v, 16'h0);

        // R6 interval length for random preloads
        for (int k = 0; k < 4; k++) begin
            p = 16'hFFF0 + 16'($urandom % 15);
            wr(2'd2, 16'h0000);
            wr(2'd3, 16'h008D);
            wr(2'd0, p);
            wr(2'd2, 16'h0003);
            wait_rise(ok);
            check("R6 first irq", {15'd0, ok}, 16'h1);
            t1 = cyc;
            check("R9 level", {13'd0, irq_level}, 16'h5);
            wr(2'd3, 16'h008D);
            check("R7 ack drops req", {15'd0, irq_req}, 16'h0);
            wait_rise(ok);
            t2 = cyc;
            check("R6 period", 16'(t2 - t1), 16'(period_cycles(p)));
        end

        // R9 gating with pending set
        wr(2'd3, 16'h0008);
        rd(2'd3, v); check("R7 bit7=0 keeps pending", v, 16'h0088);
        check("R9 level0 no req", {12'd0, irq_req, irq_level}, 16'h0);
        wr(2'd3, 16'h0003);
        check("R9 disabled no req", {12'd0, irq_req, irq_level}, 16'h0);

        // R8 ack coincident with overflow, preload FFFF overflows every tick
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'hFFFF);
        wr(2'd3, 16'h008F);
        wr(2'd2, 16'h0003);
        wait_rise(ok);
        check("R8 sync irq", {15'd0, ok}, 16'h1);
        repeat (DIV - 2) @(negedge clk);
        wr(2'd3, 16'h008F);
        rd(2'd3, v); check("R8 coincident ack keeps pending", v, 16'h008F);
        repeat (DIV - 3) @(negedge clk);
        wr(2'd3, 16'h008F);
        rd(2'd3, v); check("R7 early ack clears", v, 16'h000F);

        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0080);
        rd(2'd3, v); check("R7 final ack", v, 16'h0000);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule